// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This block performs one 32-bit multiplication or division at a time for a pipelined integer core. Each operation can be signed or unsigned. A single-cycle start command loads the two operands and the mode. A single shared datapath then runs one radix-2 step per clock: shift-and-add for a product, restoring subtraction for a quotient. The operation finishes 32 clocks after the start edge. The finished result lands in two result registers, HI and LO.

After a multiply, HI and LO hold the upper and lower halves of the 64-bit product. After a divide, LO holds the quotient and HI holds the remainder. Signed operands are turned into magnitudes before the first step, and the result signs are applied when the results are written.

The core raises a read request when it wants HI or LO. While an operation is still running, the block answers that request with a pause output that holds the pipeline. The core may also load HI or LO directly while the unit is idle. A new start while an operation is running abandons that operation.

Top module: `muldiv_iter`

## Requirements
- R1: After reset, `busy` and `pause` are 0 and `hi` and `lo` are both 0.
- R2: For an unsigned multiply, `{hi, lo}` equals the 64-bit product of `opa` and `opb`. `busy` is 1 from the clock edge that samples `start` until the 32nd edge after it, and the result is visible after that 32nd edge.
- R3: For a signed multiply, `{hi, lo}` equals the two's-complement 64-bit product of the signed operands, including the case 0x80000000 times 0x80000000.
- R4: For an unsigned divide (`op_div`=1, `op_signed`=0), `lo` is the quotient `opa / opb` and `hi` is the remainder.
- R5: For a signed divide, the quotient is rounded toward zero and is negative exactly when the operand signs differ. The remainder has the sign of the dividend `opa`.
- R6: With `opb` equal to zero, a divide gives `lo` = all ones and `hi` = `opa`, for both signed and unsigned mode, and raises no other indication.
- R7: `pause` is 1 exactly when `rd_req` is 1 while `busy` is 1. It is 0 whenever the unit is idle.
- R8: While an operation runs, `hi` and `lo` keep the values they had before it started, until the final edge.
- R9: While idle and with no `start`, `wr_hi` (or `wr_lo`) loads `wr_data` into `hi` (or `lo`) at the next edge.
- R10: `wr_hi` and `wr_lo` have no effect while `busy` is 1 or in the cycle `start` is 1.
- R11: A `start` while `busy` is 1 abandons the running operation and loads the new operands. The new result arrives 32 edges after this start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new operation with the current operands and mode |
| op_div | input | 1 | 1 selects divide, 0 selects multiply |
| op_signed | input | 1 | 1 treats both operands as two's complement |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| rd_req | input | 1 | The core is reading HI or LO this cycle |
| wr_hi | input | 1 | Load `wr_data` into HI when idle |
| wr_lo | input | 1 | Load `wr_data` into LO when idle |
| wr_data | input | 32 | Data for direct HI or LO loads |
| hi | output | 32 | HI result: upper product half or remainder |
| lo | output | 32 | LO result: lower product half or quotient |
| busy | output | 1 | An operation is in progress |
| pause | output | 1 | Stall request to the pipeline |

## Verification
The bench builds the unit at its default width of 32. The iteration counter therefore counts the full 32 steps, so the stall window can be checked edge by edge at its true length. That width also reaches the extreme operands: the most negative value as a factor and as a dividend, an all-ones unsigned product that carries through the whole upper half, and the divide-by-zero pattern. Aborting an operation and writing HI or LO during a run are placed at fixed edges inside that window.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

    // Mode captured on start: operation kind and the sign fix for each half
    typedef struct packed {
        md_op_e op;
        logic   neg_lo;
        logic   neg_hi;
    } md_mode_t;

    function automatic int cnt_bits(input int iters);
        return $clog2(iters + 1);
    endfunction

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CNT_W = cnt_bits(WIDTH)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  md_mode_t mode_d,
    output md_mode_t mode_q,
    output logic     busy,
    output logic     step,
    output logic     done
);

    localparam logic [CNT_W-1:0] LOAD_CNT = CNT_W'(WIDTH);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            mode_q <= '0;
        end else if (start) begin
            count  <= LOAD_CNT;
            mode_q <= mode_d;
        end else if (count != '0) begin
            count  <= count - 1'b1;
        end
    end

    assign busy = (count != '0);
    assign step = busy && !start;
    assign done = step && (count == {{(CNT_W-1){1'b0}}, 1'b1});

    // R11
    load_len_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && count == LOAD_CNT));

    // R2
    fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  md_op_e             op_d,
    input  md_op_e             op_q,
    input  logic [WIDTH-1:0]   mag_a,
    input  logic [WIDTH-1:0]   mag_b,
    output logic [2*WIDTH-1:0] step_next
);

    localparam int DW = 2 * WIDTH;

    logic [WIDTH-1:0] reg_a;
    logic [DW-1:0]    reg_b;
    logic [WIDTH:0]   mul_sum;
    logic [WIDTH+1:0] div_diff;
    logic             qbit;
    logic [WIDTH-1:0] rem_new;

    // Shift-and-add: accumulate into upper half, shift right one bit
    assign mul_sum = {1'b0, reg_b[DW-1:WIDTH]}
                   + (reg_b[0] ? {1'b0, reg_a} : {(WIDTH+1){1'b0}});

    // Restoring divide: trial subtract from the shifted partial remainder
    assign div_diff = {1'b0, reg_b[DW-1:WIDTH-1]} - {2'b00, reg_a};
    assign qbit     = ~div_diff[WIDTH+1];
    assign rem_new  = qbit ? div_diff[WIDTH-1:0] : reg_b[DW-2:WIDTH-1];

    always_comb begin
        if (op_q == OP_MUL)
            step_next = {mul_sum, reg_b[WIDTH-1:1]};
        else
            step_next = {rem_new, reg_b[WIDTH-2:0], qbit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a <= '0;
            reg_b <= '0;
        end else if (load) begin
            if (op_d == OP_MUL) begin
                reg_a <= mag_a;
                reg_b <= {{WIDTH{1'b0}}, mag_b};
            end else begin
                reg_a <= mag_b;
                reg_b <= {{WIDTH{1'b0}}, mag_a};
            end
        end else if (step) begin
            reg_b <= step_next;
        end
    end

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (step && op_q == OP_DIV && reg_a != '0) |=> (reg_b[DW-1:WIDTH] < reg_a));

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               done,
    input  logic               busy,
    input  logic               start,
    input  md_mode_t           mode,
    input  logic [2*WIDTH-1:0] res,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic [WIDTH-1:0]   wr_data,
    output logic [WIDTH-1:0]   hi,
    output logic [WIDTH-1:0]   lo
);

    logic [2*WIDTH-1:0] prod_fix;
    logic [WIDTH-1:0]   quo_fix;
    logic [WIDTH-1:0]   rem_fix;
    logic [WIDTH-1:0]   hi_new;
    logic [WIDTH-1:0]   lo_new;
    logic               wr_ok;

    assign prod_fix = mode.neg_hi ? -res : res;
    assign quo_fix  = mode.neg_lo ? -res[WIDTH-1:0] : res[WIDTH-1:0];
    assign rem_fix  = mode.neg_hi ? -res[2*WIDTH-1:WIDTH] : res[2*WIDTH-1:WIDTH];

    always_comb begin
        if (mode.op == OP_MUL) begin
            hi_new = prod_fix[2*WIDTH-1:WIDTH];
            lo_new = prod_fix[WIDTH-1:0];
        end else begin
            hi_new = rem_fix;
            lo_new = quo_fix;
        end
    end

    assign wr_ok = !busy && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi <= '0;
            lo <= '0;
        end else if (done) begin
            hi <= hi_new;
            lo <= lo_new;
        end else if (wr_ok) begin
            if (wr_hi) hi <= wr_data;
            if (wr_lo) lo <= wr_data;
        end
    end

    // R8 R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(hi) && $stable(lo)));

    // R9
    idle_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && wr_hi) |=> (hi == $past(wr_data)));

endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_div,
    input  logic             op_signed,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             rd_req,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo,
    output logic             busy,
    output logic             pause
);

    logic               sa;
    logic               sb;
    logic               b_zero;
    logic [WIDTH-1:0]   mag_a;
    logic [WIDTH-1:0]   mag_b;
    md_mode_t           mode_d;
    md_mode_t           mode_q;
    logic               step;
    logic               done;
    logic [2*WIDTH-1:0] step_next;

    assign sa     = op_signed & opa[WIDTH-1];
    assign sb     = op_signed & opb[WIDTH-1];
    assign b_zero = (opb == '0);
    assign mag_a  = sa ? -opa : opa;
    assign mag_b  = sb ? -opb : opb;

    always_comb begin
        mode_d.op = op_div ? OP_DIV : OP_MUL;
        if (op_div) begin
            mode_d.neg_lo = (sa ^ sb) & ~b_zero;
            mode_d.neg_hi = sa;
        end else begin
            mode_d.neg_lo = sa ^ sb;
            mode_d.neg_hi = sa ^ sb;
        end
    end

    muldiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .mode_d (mode_d),
        .mode_q (mode_q),
        .busy   (busy),
        .step   (step),
        .done   (done)
    );

    muldiv_dp #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .step      (step),
        .op_d      (mode_d.op),
        .op_q      (mode_q.op),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .step_next (step_next)
    );

    muldiv_hilo #(.WIDTH(WIDTH)) u_hilo (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .busy    (busy),
        .start   (start),
        .mode    (mode_q),
        .res     (step_next),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .hi      (hi),
        .lo      (lo)
    );

    assign pause = rd_req && busy;

    // R7
    pause_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !busy) |=> (!pause || busy));

endmodule

// File: tb/muldiv_iter_bench.sv
module muldiv_iter_bench;

    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic        op_signed = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        rd_req = 1'b0;
    logic        wr_hi = 1'b0;
    logic        wr_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] hi;
    logic [31:0] lo;
    logic        busy;
    logic        pause;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    muldiv_iter u_muldiv_iter (
        .clk(clk), .rst(rst), .start(start), .op_div(op_div),
        .op_signed(op_signed), .opa(opa), .opb(opb), .rd_req(rd_req),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .hi(hi), .lo(lo), .busy(busy), .pause(pause)
    );

    // {req, div, signed, a, b, exp_hi, exp_lo}
    localparam logic [133:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 32'd6,        32'd7,        32'h0,        32'd42},       // R2
        {4'd2, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001}, // R2
        {4'd2, 1'b0, 1'b0, 32'h12345678, 32'h10,       32'h1,        32'h23456780}, // R2
        {4'd3, 1'b0, 1'b1, 32'hFFFFFFFD, 32'd5,        32'hFFFFFFFF, 32'hFFFFFFF1}, // R3
        {4'd3, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h1},        // R3
        {4'd3, 1'b0, 1'b1, 32'h80000000, 32'h80000000, 32'h40000000, 32'h0},        // R3
        {4'd4, 1'b1, 1'b0, 32'd100,      32'd7,        32'd2,        32'd14},       // R4
        {4'd4, 1'b1, 1'b0, 32'hFFFFFFFF, 32'd10,       32'd5,        32'h19999999}, // R4
        {4'd5, 1'b1, 1'b1, 32'hFFFFFFF9, 32'd2,        32'hFFFFFFFF, 32'hFFFFFFFD}, // R5
        {4'd5, 1'b1, 1'b1, 32'd7,        32'hFFFFFFFE, 32'd1,        32'hFFFFFFFD}, // R5
        {4'd5, 1'b1, 1'b1, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'd3},        // R5
        {4'd5, 1'b1, 1'b1, 32'h80000000, 32'hFFFFFFFF, 32'h0,        32'h80000000}, // R5
        {4'd6, 1'b1, 1'b0, 32'd1234,     32'd0,        32'd1234,     32'hFFFFFFFF}, // R6
        {4'd6, 1'b1, 1'b1, 32'hFFFFFFFB, 32'd0,        32'hFFFFFFFB, 32'hFFFFFFFF}  // R6
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic launch(input logic dv, input logic sg, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_div = dv; op_signed = sg; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] ph;
        logic [31:0] pl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", {31'd0, busy, 31'd0, pause}, 64'd0);
        chk("R1", {hi, lo}, 64'd0);

        // R7 idle read: no pause
        rd_req = 1'b1; #1;
        chk("R7", {63'd0, pause}, 64'd0);
        rd_req = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][133:130]);
            ph = hi; pl = lo;
            launch(VEC[i][129], VEC[i][128], VEC[i][127:96], VEC[i][95:64]);
            chk("R2", {63'd0, busy}, 64'd1);
            rd_req = 1'b1; #1;
            chk("R7", {63'd0, pause}, 64'd1);
            rd_req = 1'b0;
            repeat (31) @(negedge clk);
            chk("R2", {63'd0, busy}, 64'd1);
            chk("R8", {hi, lo}, {ph, pl});
            @(negedge clk);
            chk("R2", {63'd0, busy}, 64'd0);
            chk(tag, {hi, lo}, VEC[i][63:0]);
        end

        // R9 direct loads while idle
        @(negedge clk);
        wr_hi = 1'b1; wr_data = 32'hA5A5_0F0F;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 32'h1357_9BDF;
        @(negedge clk);
        wr_lo = 1'b0;
        chk("R9", {hi, lo}, {32'hA5A5_0F0F, 32'h1357_9BDF});

        // R10 write during a run is ignored
        launch(1'b0, 1'b0, 32'd2, 32'd2);
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b0;
        chk("R10", {hi, lo}, {32'hA5A5_0F0F, 32'h1357_9BDF});
        repeat (30) @(negedge clk);
        chk("R10", {63'd0, busy}, 64'd1);
        @(negedge clk);
        chk("R10", {hi, lo}, {32'd0, 32'd4});

        // R10 write in the start cycle is ignored
        @(negedge clk);
        op_div = 1'b0; op_signed = 1'b0; opa = 32'd3; opb = 32'd5; start = 1'b1;
        wr_lo = 1'b1; wr_data = 32'h0000_0055;
        @(negedge clk);
        start = 1'b0; wr_lo = 1'b0;
        chk("R10", {hi, lo}, {32'd0, 32'd4});
        repeat (32) @(negedge clk);
        chk("R10", {hi, lo}, {32'd0, 32'd15});

        // R11 abort and restart
        launch(1'b0, 1'b0, 32'd6, 32'd7);
        repeat (10) @(negedge clk);
        launch(1'b1, 1'b0, 32'd50, 32'd6);
        repeat (31) @(negedge clk);
        chk("R11", {63'd0, busy}, 64'd1);
        chk("R11", {hi, lo}, {32'd0, 32'd15});
        @(negedge clk);
        chk("R11", {31'd0, busy, hi}, {32'd0, 32'd2});
        chk("R11", {32'd0, lo}, {32'd0, 32'd8});

        // R1 reset during a run
        launch(1'b0, 1'b0, 32'd9, 32'd9);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", {hi, lo}, 64'd0);
        chk("R1", {63'd0, busy}, 64'd0);

        summary();
    end

endmodule